// File: doc/BRIEF.md
# Redirected interrupt routing controller

This block sits between a set of device interrupt lines and the processors that service them. Each of its 24 inputs owns a 64-bit routing entry. The entry holds the vector that the input delivers, its polarity, whether it is edge- or level-sensitive, a mask, and the destination processor. When an unmasked input becomes active, the block builds a message from that entry and offers it on a valid/ready port. Several inputs may be waiting at once. The message with the highest vector goes first, so the input number does not set the priority.

Software programs the block through two registers. A write with `reg_sel` low loads an 8-bit index. Accesses with `reg_sel` high then read or write the 32-bit register that the index points at. Level-sensitive inputs are held off after delivery until the processor sends an end-of-interrupt carrying the same vector.

Top module: `irq_router`

## Requirements
- R1: A write with `reg_sel`=0 loads `reg_wdata[7:0]` into the index. A write with `reg_sel`=1 goes to the register the index selects. `reg_rdata` always shows that register.
- R2: Entry n has its low word at index 0x10+2n and its high word at 0x10+2n+1. The low word fields are: [7:0] vector, [13] polarity (1 = active low), [14] remote-pending (read-only), [15] trigger (1 = level), [16] mask (1 = masked). Delivery mode [10:8] reads 000 (fixed) and destination mode [11] reads 0 (physical). The high word holds the destination in [31:24] and zeros elsewhere.
- R3: A masked entry sends no message. Rewriting the low word with only the mask bit changed leaves every other field as it was.
- R4: Index 0x01 reads 0x0017_0020, with the entry count minus one (23) in bits [23:16]. Writes to it are ignored.
- R5: An edge entry sends one message for each inactive-to-active transition. Polarity is applied to the input before edge detection.
- R6: Among waiting entries, the highest vector is sent first. On equal vectors the lower input number wins.
- R7: Acceptance of a level entry's message sets its remote-pending bit, and no further message is sent from that entry while the bit is set. An end-of-interrupt whose vector matches clears the bit. An input that is still active then triggers again. An end-of-interrupt with another vector has no effect.
- R8: After reset, every low word reads 0x0001_0000 (edge, active high, masked, vector 0) and every high word reads 0.
- R9: While `msg_valid` is high and `msg_ready` is low, the message fields stay unchanged and valid stays high.
- R10: Any index other than 0x01 and 0x10..0x3F reads as zero, and writes to it change nothing.
- R11: A message carries the entry's vector, its destination, and `msg_level`=1 for level entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = index register, 1 = data register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register selected by the index |
| irq_in | input | 24 | Interrupt lines, synchronous to clk |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being ended |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_level | output | 1 | Message comes from a level entry |

## Verification
The properties assume that `irq_in` and `eoi_vector` are already synchronous to `clk`. They also assume that software may rewrite an entry while that entry's message is waiting, so every check looks at the entry state one cycle back rather than at the current state. The bench meets the first assumption by changing every input one nanosecond after the falling edge. It exercises the second on purpose: in a randomized phase it rewrites table entries and issues end-of-interrupts while messages are stalled.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM = 24,
  parameter logic [7:0] BASE = 8'h10,
  parameter logic [7:0] VER_IDX = 8'h01,
  parameter logic [7:0] REV = 8'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NUM-1:0]  irq_in,
  input  logic            eoi_valid,
  input  logic [7:0]      eoi_vector,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [7:0]      msg_vector,
  output logic [7:0]      msg_dest,
  output logic            msg_level
);
  localparam int IW = $clog2(NUM);
  localparam logic [7:0] END = BASE + 8'(2 * NUM);

  logic [7:0]     idx_q;
  logic [7:0]     vec_q [NUM];
  logic [7:0]     dst_q [NUM];
  logic [NUM-1:0] pol_q, trig_q, mask_q, rem_q, pend_q, prev_q;
  logic [IW-1:0]  midx_q;

  wire [NUM-1:0] act    = irq_in ^ pol_q;
  wire [NUM-1:0] req    = ~mask_q & ((trig_q & act & ~rem_q) | (~trig_q & pend_q));
  wire [7:0]     off    = idx_q - BASE;
  wire [IW-1:0]  ent    = off[IW:1];
  wire           in_tbl = (idx_q >= BASE) && (idx_q < END);
  wire           accept = msg_valid & msg_ready;

  logic          found;
  logic [IW-1:0] best;
  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NUM; i++)
      if (req[i] && (!found || vec_q[i] > vec_q[best])) begin
        found = 1'b1;
        best  = IW'(i);
      end
  end

  always_comb begin
    reg_rdata = '0;
    if (idx_q == VER_IDX)
      reg_rdata = {8'h00, 8'(NUM - 1), 8'h00, REV};
    else if (in_tbl && !off[0])
      reg_rdata = {15'b0, mask_q[ent], trig_q[ent], rem_q[ent], pol_q[ent], 5'b0, vec_q[ent]};
    else if (in_tbl)
      reg_rdata = {dst_q[ent], 24'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      pol_q <= '0; trig_q <= '0; mask_q <= '1;
      rem_q <= '0; pend_q <= '0; prev_q <= '0;
      msg_valid <= 1'b0; msg_vector <= '0; msg_dest <= '0; msg_level <= 1'b0;
      midx_q <= '0;
      for (int i = 0; i < NUM; i++) begin
        vec_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      if (reg_we && !reg_sel) idx_q <= reg_wdata[7:0];
      prev_q <= act;
      if (msg_valid) begin
        if (msg_ready) msg_valid <= 1'b0;
      end else if (found) begin
        msg_valid  <= 1'b1;
        msg_vector <= vec_q[best];
        msg_dest   <= dst_q[best];
        msg_level  <= trig_q[best];
        midx_q     <= best;
      end
      for (int i = 0; i < NUM; i++) begin
        if (reg_we && reg_sel && in_tbl && ent == IW'(i)) begin
          if (!off[0]) begin
            vec_q[i]  <= reg_wdata[7:0];
            pol_q[i]  <= reg_wdata[13];
            trig_q[i] <= reg_wdata[15];
            mask_q[i] <= reg_wdata[16];
          end else begin
            dst_q[i] <= reg_wdata[31:24];
          end
        end
        if (!trig_q[i] && act[i] && !prev_q[i] && !mask_q[i])
          pend_q[i] <= 1'b1;
        else if (accept && !msg_level && midx_q == IW'(i))
          pend_q[i] <= 1'b0;
        if (accept && msg_level && midx_q == IW'(i))
          rem_q[i] <= 1'b1;
        else if (eoi_valid && vec_q[i] == eoi_vector)
          rem_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM = 24,
  parameter logic [7:0] BASE = 8'h10,
  parameter logic [7:0] VER_IDX = 8'h01
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   msg_valid,
  input logic                   msg_ready,
  input logic [7:0]             msg_vector,
  input logic [7:0]             msg_dest,
  input logic                   msg_level,
  input logic [$clog2(NUM)-1:0] msg_idx,
  input logic [NUM-1:0]         mask_v,
  input logic [NUM-1:0]         rem_v,
  input logic [7:0]             idx,
  input logic [31:0]            rdata
);
  localparam logic [7:0] END = BASE + 8'(2 * NUM);
  localparam logic [NUM-1:0] ONE = NUM'(1);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_level));

  assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (($past(mask_v) >> msg_idx) & ONE) == '0);

  assert_remote_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_level |=> ((rem_v >> $past(msg_idx)) & ONE) != '0);

  assert_level_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && msg_level |-> (($past(rem_v) >> msg_idx) & ONE) == '0);

  assert_unimpl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != VER_IDX) && !((idx >= BASE) && (idx < END)) |-> rdata == '0);

  assert_version_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx == VER_IDX |-> rdata[23:16] == 8'(NUM - 1));
endmodule

bind irq_router irq_router_chk #(.NUM(NUM), .BASE(BASE), .VER_IDX(VER_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_level(msg_level),
  .msg_idx(midx_q), .mask_v(mask_q), .rem_v(rem_q), .idx(idx_q), .rdata(reg_rdata)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_we, reg_sel, eoi_valid, msg_valid, msg_ready, msg_level;
  logic [31:0] reg_wdata, reg_rdata;
  logic [23:0] irq_in;
  logic [7:0]  eoi_vector, msg_vector, msg_dest;

  irq_router u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_level(msg_level)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] acc_q[$];
  bit [7:0] vlist[4] = '{8'h20, 8'h40, 8'h55, 8'h90};

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  // behavioural reference model
  bit [7:0]  m_vec[24];
  bit [7:0]  m_dst[24];
  bit [23:0] m_pol, m_trig, m_mask, m_rem, m_pend, m_prev;
  bit [7:0]  m_idx, m_mv, m_md;
  bit        m_v, m_lvl;
  int        m_mi;

  function automatic logic [31:0] m_read(bit [7:0] ix);
    int e;
    if (ix == 8'h01) return 32'h0017_0020;
    if (ix < 8'h10 || ix >= 8'h40) return 32'h0;
    e = (int'(ix) - 16) / 2;
    if (ix[0]) return {m_dst[e], 24'h0};
    return {15'h0, m_mask[e], m_trig[e], m_rem[e], m_pol[e], 5'h0, m_vec[e]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 24; i++) begin m_vec[i] = 0; m_dst[i] = 0; end
      m_pol = 0; m_trig = 0; m_mask = '1; m_rem = 0; m_pend = 0; m_prev = 0;
      m_idx = 0; m_v = 0; m_mv = 0; m_md = 0; m_lvl = 0; m_mi = 0;
    end else begin
      bit [23:0] act, np, nr;
      bit acc;
      int best;
      act = irq_in ^ m_pol;
      acc = m_v && msg_ready;
      best = -1;
      for (int i = 0; i < 24; i++) begin
        bit rq;
        rq = !m_mask[i] && (m_trig[i] ? (act[i] && !m_rem[i]) : m_pend[i]);
        if (rq && (best < 0 || m_vec[i] > m_vec[best])) best = i;
        np[i] = m_pend[i];
        if (!m_trig[i] && act[i] && !m_prev[i] && !m_mask[i]) np[i] = 1;
        else if (acc && !m_lvl && m_mi == i) np[i] = 0;
        nr[i] = m_rem[i];
        if (acc && m_lvl && m_mi == i) nr[i] = 1;
        else if (eoi_valid && m_vec[i] == eoi_vector) nr[i] = 0;
      end
      if (m_v) begin
        if (msg_ready) m_v = 0;
      end else if (best >= 0) begin
        m_v = 1; m_mv = m_vec[best]; m_md = m_dst[best];
        m_lvl = m_trig[best]; m_mi = best;
      end
      if (reg_we && reg_sel && m_idx >= 8'h10 && m_idx < 8'h40) begin
        int e;
        e = (int'(m_idx) - 16) / 2;
        if (!m_idx[0]) begin
          m_vec[e] = reg_wdata[7:0]; m_pol[e] = reg_wdata[13];
          m_trig[e] = reg_wdata[15]; m_mask[e] = reg_wdata[16];
        end else m_dst[e] = reg_wdata[31:24];
      end
      if (reg_we && !reg_sel) m_idx = reg_wdata[7:0];
      m_pend = np; m_rem = nr; m_prev = act;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 msg_valid", 32'(msg_valid), 32'(m_v));
      if (m_v) begin
        chk("R11 msg_vector", 32'(msg_vector), 32'(m_mv));
        chk("R11 msg_dest", 32'(msg_dest), 32'(m_md));
        chk("R11 msg_level", 32'(msg_level), 32'(m_lvl));
      end
      chk("R2 reg_rdata", reg_rdata, m_read(m_idx));
    end
    #2;
    if (rst_n && msg_valid && msg_ready) acc_q.push_back({msg_dest, msg_vector});
  end

  task automatic wr(input bit [7:0] ix, input logic [31:0] v);
    @(negedge clk); #1 reg_we = 1; reg_sel = 0; reg_wdata = 32'(ix);
    @(negedge clk); #1 reg_sel = 1; reg_wdata = v;
    @(negedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(input bit [7:0] ix, output logic [31:0] v);
    @(negedge clk); #1 reg_we = 1; reg_sel = 0; reg_wdata = 32'(ix);
    @(negedge clk); #1 reg_we = 0; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    finish_run;
  end

  initial begin
    logic [31:0] v, v1, d1;
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0; irq_in = 0;
    eoi_valid = 0; eoi_vector = 0; msg_ready = 1;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;

    rd(8'h10, v); chk("R8 entry0 low", v, 32'h0001_0000);
    rd(8'h3E, v); chk("R8 entry23 low", v, 32'h0001_0000);
    rd(8'h3F, v); chk("R8 entry23 high", v, 32'h0);
    rd(8'h01, v); chk("R4 version", v, 32'h0017_0020);
    wr(8'h01, 32'h0);
    rd(8'h01, v); chk("R4 version read-only", v, 32'h0017_0020);
    rd(8'h05, v); chk("R10 unimplemented", v, 32'h0);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h05, v); chk("R10 write ignored", v, 32'h0);
    rd(8'h40, v); chk("R10 past table", v, 32'h0);
    wr(8'h11, 32'h7700_0000);
    rd(8'h10, v); chk("R1 low word untouched", v, 32'h0001_0000);
    rd(8'h11, v); chk("R1 high word via index", v, 32'h7700_0000);

    // R5 edge entry 3
    wr(8'h17, 32'hA500_0000);
    wr(8'h16, 32'h0000_0040);
    acc_q.delete();
    irq_in[3] = 1; idle(5); irq_in[3] = 0; idle(5);
    chk("R5 one message per edge", 32'(acc_q.size()), 32'd1);
    if (acc_q.size() > 0) chk("R11 edge message dest/vector", 32'(acc_q[0]), 32'h0000_A540);

    // R5 polarity entry 5
    irq_in[5] = 1;
    wr(8'h1A, 32'h0000_2030);
    acc_q.delete(); idle(4);
    chk("R5 inactive low-polarity input", 32'(acc_q.size()), 32'd0);
    irq_in[5] = 0; idle(5); irq_in[5] = 1; idle(5);
    chk("R5 active-low edge", 32'(acc_q.size()), 32'd1);
    if (acc_q.size() > 0) chk("R5 active-low vector", 32'(acc_q[0][7:0]), 32'h30);

    // R3 mask
    wr(8'h16, 32'h0001_0040);
    rd(8'h16, v); chk("R3 mask set keeps fields", v, 32'h0001_0040);
    acc_q.delete();
    irq_in[3] = 1; idle(4); irq_in[3] = 0; idle(4);
    chk("R3 masked no message", 32'(acc_q.size()), 32'd0);
    wr(8'h16, 32'h0000_0040);
    rd(8'h16, v); chk("R3 mask clear keeps fields", v, 32'h0000_0040);

    // R6 priority and R9 hold
    msg_ready = 0;
    wr(8'h14, 32'h0000_0020); wr(8'h15, 32'h0200_0000);
    wr(8'h38, 32'h0000_0090); wr(8'h39, 32'h1400_0000);
    wr(8'h24, 32'h0000_0090); wr(8'h25, 32'h0A00_0000);
    acc_q.delete();
    irq_in[2] = 1; irq_in[10] = 1; irq_in[20] = 1; idle(3);
    irq_in[2] = 0; irq_in[10] = 0; irq_in[20] = 0; idle(3);
    v1 = 32'(msg_vector); d1 = 32'(msg_dest);
    idle(3);
    chk("R9 valid held", 32'(msg_valid), 32'd1);
    chk("R9 vector held", 32'(msg_vector), v1);
    chk("R9 dest held", 32'(msg_dest), d1);
    msg_ready = 1; idle(8);
    chk("R6 three messages", 32'(acc_q.size()), 32'd3);
    if (acc_q.size() == 3) begin
      chk("R6 tie lowest index first", 32'(acc_q[0]), 32'h0000_0A90);
      chk("R6 second equal vector", 32'(acc_q[1]), 32'h0000_1490);
      chk("R6 lowest vector last", 32'(acc_q[2]), 32'h0000_0220);
    end

    // R7 level entry 7
    wr(8'h1E, 32'h0000_8055);
    acc_q.delete();
    irq_in[7] = 1; idle(8);
    chk("R7 single level message", 32'(acc_q.size()), 32'd1);
    rd(8'h1E, v); chk("R7 remote bit set", v, 32'h0000_C055);
    eoi_valid = 1; eoi_vector = 8'h56; idle(1); eoi_valid = 0; idle(5);
    chk("R7 wrong eoi ignored", 32'(acc_q.size()), 32'd1);
    rd(8'h1E, v); chk("R7 remote kept", v, 32'h0000_C055);
    eoi_valid = 1; eoi_vector = 8'h55; idle(1); eoi_valid = 0; idle(6);
    chk("R7 retrigger after eoi", 32'(acc_q.size()), 32'd2);
    irq_in[7] = 0; idle(2);
    eoi_valid = 1; idle(1); eoi_valid = 0; idle(6);
    chk("R7 no message once inactive", 32'(acc_q.size()), 32'd2);
    rd(8'h1E, v); chk("R7 remote cleared", v, 32'h0000_8055);

    // randomized phase checked against the model every cycle
    for (int c = 0; c < 800; c++) begin
      @(negedge clk); #1;
      if ($urandom % 3 == 0) irq_in[$urandom % 24] ^= 1'b1;
      msg_ready = 1'($urandom % 2);
      eoi_valid = ($urandom % 8 == 0);
      eoi_vector = vlist[$urandom % 4];
      if (c % 25 == 0) begin
        logic [31:0] lo;
        lo = 32'(vlist[$urandom % 4]);
        if ($urandom % 2) lo |= 32'h2000;
        if ($urandom % 2) lo |= 32'h8000;
        if ($urandom % 3 == 0) lo |= 32'h1_0000;
        wr(8'(16 + 2 * ($urandom % 24)), lo);
      end
    end
    eoi_valid = 0; msg_ready = 1; idle(5);
    finish_run;
  end
endmodule